// File: doc/BRIEF.md
# 8-bit ALU with Digit Carry

A purely combinational arithmetic and logic unit for a small accumulator processor. Each operation takes two 8-bit operands, a carry-in taken from the status register and a 4-bit operation code. It returns an 8-bit result, new values for the zero (Z), digit-carry (DC) and carry (C) flags, and a three-bit flag mask. The mask tells the status register which flags this operation may change.

Addition is built from two 4-bit stages, so the carry out of bit 3 comes straight out of the low stage as DC. Subtraction adds the two's complement of the second operand. C and DC are therefore inverted borrows: 1 means no borrow. Rotates pass through the carry-in. The bit-manipulation, swap and move operations leave every flag alone.

Instruction decode, register file access and the status register itself sit outside the block.

Top module: `alu8_dc`

## Requirements
- R1: Code 4'h1 (add) gives res = (a+b) mod 256. C is the carry out of bit 7, DC is the carry out of bit 3 into bit 4, and the mask is 3'b111.
- R2: Code 4'h2 (subtract) gives res = (a-b) mod 256. C is 1 exactly when a >= b, DC is 1 exactly when a[3:0] >= b[3:0], and the mask is 3'b111.
- R3: Whenever mask bit 2 (Z) is set, z is 1 exactly when the 8-bit result is zero.
- R4: The codes 4'h0 (pass a), 4'h3 (a AND b), 4'h4 (a OR b), 4'h5 (a XOR b) and 4'h6 (NOT a) give the stated result with mask 3'b100.
- R5: Code 4'h7 gives a+1 and code 4'h8 gives a-1, both modulo 256 and both with mask 3'b100.
- R6: Code 4'h9 (rotate right through carry) gives res = {cin, a[7:1]} and C = a[0], with mask 3'b001.
- R7: Code 4'hA (rotate left through carry) gives res = {a[6:0], cin} and C = a[7], with mask 3'b001.
- R8: The following codes all have mask 3'b000:
  - 4'hB swaps the nibbles of a.
  - 4'hC sets bit b[2:0] of a.
  - 4'hD clears bit b[2:0] of a.
  - 4'hE returns b.
- R9: The unused code 4'hF returns a unchanged with mask 3'b000.
- R10: A flag output whose mask bit is 0 is driven 0. The mask bits are Z in bit 2, DC in bit 1 and C in bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 8 | First operand |
| b_i | input | 8 | Second operand, or bit index in b_i[2:0] |
| cin_i | input | 1 | Carry-in from the status register |
| op_i | input | 4 | Operation code |
| res_o | output | 8 | Result |
| z_o | output | 1 | Zero flag |
| dc_o | output | 1 | Digit carry, or inverted digit borrow |
| c_o | output | 1 | Carry, or inverted borrow |
| fmask_o | output | 3 | Flags affected: {Z, DC, C} |

## Verification
The hardest case to reach is the digit flag at its boundary. It must be exact when the low nibbles carry or borrow by exactly one, and at the same time the full byte must wrap to zero, so that Z, DC and C all flip together. Random operands land on these cases only rarely. The stimulus therefore sweeps every operand pair for both add and subtract, with a random carry-in that must not leak into either operation. Random vectors then cover the other codes, and directed vectors cover the rotate end bits and the unused code.

// File: rtl/alu8_dc.sv
module alu8_dc (
  input  logic [7:0] a_i,
  input  logic [7:0] b_i,
  input  logic       cin_i,
  input  logic [3:0] op_i,
  output logic [7:0] res_o,
  output logic       z_o,
  output logic       dc_o,
  output logic       c_o,
  output logic [2:0] fmask_o
);
  localparam logic [3:0] OP_PASSA = 4'h0, OP_ADD = 4'h1, OP_SUB = 4'h2,
                         OP_AND = 4'h3, OP_OR = 4'h4, OP_XOR = 4'h5,
                         OP_NOT = 4'h6, OP_INC = 4'h7, OP_DEC = 4'h8,
                         OP_RRC = 4'h9, OP_RLC = 4'hA, OP_SWAP = 4'hB,
                         OP_BSET = 4'hC, OP_BCLR = 4'hD, OP_PASSB = 4'hE;
  localparam logic [2:0] M_ALL = 3'b111, M_Z = 3'b100, M_C = 3'b001, M_NONE = 3'b000;

  logic       sub;
  logic [7:0] bx;
  logic [4:0] lo, hi;
  logic [7:0] bitsel;

  assign sub    = (op_i == OP_SUB);
  assign bx     = sub ? ~b_i : b_i;
  assign lo     = {1'b0, a_i[3:0]} + {1'b0, bx[3:0]} + {4'b0, sub};
  assign hi     = {1'b0, a_i[7:4]} + {1'b0, bx[7:4]} + {4'b0, lo[4]};
  assign bitsel = 8'd1 << b_i[2:0];

  logic [7:0] res;
  logic       fc, fdc;
  logic [2:0] m;

  always_comb begin
    res = a_i;
    fc  = 1'b0;
    fdc = 1'b0;
    m   = M_NONE;
    case (op_i)
      OP_PASSA: m = M_Z;
      OP_ADD, OP_SUB: begin
        res = {hi[3:0], lo[3:0]};
        fc  = hi[4];
        fdc = lo[4];
        m   = M_ALL;
      end
      OP_AND:   begin res = a_i & b_i; m = M_Z; end
      OP_OR:    begin res = a_i | b_i; m = M_Z; end
      OP_XOR:   begin res = a_i ^ b_i; m = M_Z; end
      OP_NOT:   begin res = ~a_i;      m = M_Z; end
      OP_INC:   begin res = a_i + 8'd1; m = M_Z; end
      OP_DEC:   begin res = a_i - 8'd1; m = M_Z; end
      OP_RRC:   begin res = {cin_i, a_i[7:1]}; fc = a_i[0]; m = M_C; end
      OP_RLC:   begin res = {a_i[6:0], cin_i}; fc = a_i[7]; m = M_C; end
      OP_SWAP:  res = {a_i[3:0], a_i[7:4]};
      OP_BSET:  res = a_i | bitsel;
      OP_BCLR:  res = a_i & ~bitsel;
      OP_PASSB: res = b_i;
      default:  res = a_i;
    endcase
  end

  assign res_o   = res;
  assign fmask_o = m;
  assign z_o     = m[2] & (res == 8'd0);
  assign dc_o    = m[1] & fdc;
  assign c_o     = m[0] & fc;

  always_comb begin
    if (op_i == OP_ADD)
      a_r1_add_sum: assert ({c_o, res_o} == ({1'b0, a_i} + {1'b0, b_i}))
        else $error("R1 add sum/carry mismatch");
    if (op_i == OP_SUB)
      a_r2_sub_borrow: assert ((c_o == (a_i >= b_i)) && (res_o == a_i - b_i))
        else $error("R2 subtract borrow mismatch");
    if (op_i == OP_RRC)
      a_r6_rrc: assert ({res_o, c_o} == {cin_i, a_i})
        else $error("R6 rotate right mismatch");
    if (op_i == OP_RLC)
      a_r7_rlc: assert ({c_o, res_o} == {a_i, cin_i})
        else $error("R7 rotate left mismatch");
    if (op_i == 4'hF)
      a_r9_unused: assert ((res_o == a_i) && (fmask_o == 3'b000))
        else $error("R9 unused code mismatch");
  end
endmodule

// File: tb/alu8_dc_tb_top.sv
`timescale 1ns/1ps
module alu8_dc_tb_top;
  logic       clk = 1'b0;
  logic [7:0] a, b;
  logic       cin;
  logic [3:0] op;
  logic [7:0] res;
  logic       z, dc, c;
  logic [2:0] fm;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  alu8_dc dut_i (.a_i(a), .b_i(b), .cin_i(cin), .op_i(op),
                 .res_o(res), .z_o(z), .dc_o(dc), .c_o(c), .fmask_o(fm));

  function automatic logic [13:0] model(input logic [3:0] o, input logic [7:0] x,
                                        input logic [7:0] y, input logic ci);
    logic [8:0] s9; logic [4:0] n5;
    logic [7:0] r; logic fz, fd, fc; logic [2:0] m;
    r = x; fd = 0; fc = 0; m = 3'b000;
    case (o)
      4'h0: m = 3'b100;
      4'h1: begin
        s9 = {1'b0, x} + {1'b0, y}; n5 = {1'b0, x[3:0]} + {1'b0, y[3:0]};
        r = s9[7:0]; fc = s9[8]; fd = n5[4]; m = 3'b111;
      end
      4'h2: begin
        s9 = {1'b1, x} - {1'b0, y}; n5 = {1'b1, x[3:0]} - {1'b0, y[3:0]};
        r = s9[7:0]; fc = s9[8]; fd = n5[4]; m = 3'b111;
      end
      4'h3: begin r = x & y; m = 3'b100; end
      4'h4: begin r = x | y; m = 3'b100; end
      4'h5: begin r = x ^ y; m = 3'b100; end
      4'h6: begin r = ~x; m = 3'b100; end
      4'h7: begin r = x + 8'd1; m = 3'b100; end
      4'h8: begin r = x - 8'd1; m = 3'b100; end
      4'h9: begin r = {ci, x[7:1]}; fc = x[0]; m = 3'b001; end
      4'hA: begin r = {x[6:0], ci}; fc = x[7]; m = 3'b001; end
      4'hB: r = {x[3:0], x[7:4]};
      4'hC: begin r = x; r[y[2:0]] = 1'b1; end
      4'hD: begin r = x; r[y[2:0]] = 1'b0; end
      4'hE: r = y;
      default: r = x;
    endcase
    fz = m[2] & (r == 8'd0);
    return {r, fz, fd & m[1], fc & m[0], m};
  endfunction

  function automatic string tag(input logic [3:0] o);
    case (o)
      4'h1: return "R1/R3/R10";
      4'h2: return "R2/R3/R10";
      4'h0, 4'h3, 4'h4, 4'h5, 4'h6: return "R4/R3/R10";
      4'h7, 4'h8: return "R5/R3/R10";
      4'h9: return "R6/R10";
      4'hA: return "R7/R10";
      4'hF: return "R9";
      default: return "R8";
    endcase
  endfunction

  task automatic apply(input logic [3:0] o, input logic [7:0] x,
                       input logic [7:0] y, input logic ci);
    logic [13:0] exp, got;
    @(negedge clk);
    op = o; a = x; b = y; cin = ci;
    #2;
    exp = model(o, x, y, ci);
    got = {res, z, dc, c, fm};
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s op=%h a=%h b=%h cin=%b actual res/z/dc/c/mask=%h/%b%b%b/%b expected %h/%b%b%b/%b",
               tag(o), o, x, y, ci, got[13:6], got[5], got[4], got[3], got[2:0],
               exp[13:6], exp[5], exp[4], exp[3], exp[2:0]);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    op = 4'hF; a = 8'h00; b = 8'h00; cin = 1'b0;
    apply(4'hF, 8'hA5, 8'h3C, 1'b1);   // R9 unused code
    apply(4'h1, 8'h80, 8'h80, 1'b1);   // R1 R3 wrap to zero, C set, DC clear
    apply(4'h1, 8'h0F, 8'h01, 1'b0);   // R1 digit carry only
    apply(4'h2, 8'h37, 8'h37, 1'b0);   // R2 R3 equal: no borrow, zero
    apply(4'h2, 8'h10, 8'h01, 1'b1);   // R2 digit borrow only
    apply(4'h2, 8'h00, 8'h01, 1'b1);   // R2 full borrow
    apply(4'h7, 8'hFF, 8'h00, 1'b0);   // R5 R3 increment wraps to zero
    apply(4'h8, 8'h00, 8'h00, 1'b1);   // R5 decrement wraps
    apply(4'h9, 8'h01, 8'h00, 1'b1);   // R6 bit0 out, cin in
    apply(4'hA, 8'h80, 8'h00, 1'b0);   // R7 bit7 out
    apply(4'hB, 8'h00, 8'h00, 1'b1);   // R8 zero result, no Z
    apply(4'hC, 8'h00, 8'hFF, 1'b0);   // R8 bit index from b[2:0]
    apply(4'hD, 8'hFF, 8'h03, 1'b0);   // R8
    apply(4'h6, 8'hFF, 8'h00, 1'b1);   // R4 R3 NOT to zero
    for (int x = 0; x < 256; x++)
      for (int y = 0; y < 256; y++) begin
        apply(4'h1, x[7:0], y[7:0], 1'($urandom));   // R1 sweep
        apply(4'h2, x[7:0], y[7:0], 1'($urandom));   // R2 sweep
      end
    for (int i = 0; i < 4000; i++)
      apply(4'($urandom), 8'($urandom), 8'($urandom), 1'($urandom));
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule